// File: doc/BRIEF.md
# Per-Source Reassembly Output Queue Bank

This block stands in front of a single egress port of a switch whose shared data-path carries fragments from several ingress ports interleaved beat by beat. Every fragment carries its ingress port number, its egress port number and an end-of-packet flag. The bank takes only the fragments addressed to its own egress port. It steers each one into a FIFO that is reserved for the fragment's ingress port. Because fragments from one ingress port arrive in order, each FIFO rebuilds complete packets. There is no FIFO for the egress port's own number, since traffic never returns to the port it came from.

A packet-level round-robin arbiter picks among the FIFOs that hold data. It sends one packet at a time on an AXI4-Stream master interface, and it never interleaves beats of different packets there. The bank never stalls the data-path. When a packet starts and its FIFO cannot take a packet of the maximum size, the whole packet is discarded up to its final fragment.

Top module: `reassembly_queue_bank`

## Requirements
- R1: After reset every queue is empty and `m_tvalid` is low.
- R2: A fragment with `in_dst` equal to `PORT_ID` goes into the queue of its source. Queue q serves ingress port q when q < `PORT_ID`, and ingress port q+1 otherwise. `m_tuser` carries the ingress port number of the packet being sent.
- R3: A fragment whose `in_dst` differs from `PORT_ID`, or whose `in_src` equals `PORT_ID`, has no effect on any queue or output.
- R4: Each accepted packet leaves with its fragments in arrival order and unchanged.
- R5: `m_tlast` is high on the final beat of each packet and on no other beat. Once the first beat of a packet is presented, only that packet's beats appear until its `m_tlast` beat is accepted.
- R6: After a packet from queue q completes, the next packet comes from the first non-empty queue found by searching q+1, q+2, … with wrap-around.
- R7: The arbiter is work-conserving. `m_tvalid` rises in the cycle after the first fragment is written into an otherwise empty bank.
- R8: At the first fragment of a packet, the packet is accepted if the queue's free entries are at least ceil(`MAX_PKT_BYTES` / (`DATA_W`/8)). Otherwise that fragment and every later fragment of the packet, up to and including its last, are discarded. The next packet is judged afresh.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tlast` and `m_tuser` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Fragment present on the data-path |
| in_src | input | $clog2(N_PORTS) | Ingress port of the fragment |
| in_dst | input | $clog2(N_PORTS) | Egress port of the fragment |
| in_data | input | DATA_W | Fragment payload |
| in_last | input | 1 | Final fragment of its packet |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Egress port accepts the beat |
| m_tdata | output | DATA_W | Output beat payload |
| m_tlast | output | 1 | Final beat of the packet |
| m_tuser | output | $clog2(N_PORTS) | Ingress port of the packet being sent |

## Verification
The bench uses four ports with the bank sitting at port 1, a 16-bit fragment, eight-entry queues and an 8-byte maximum packet. With these values a worst-case packet is four fragments, and a queue holds only two of them. Sweeping packet counts of zero to four per source, with lengths of one to four fragments, therefore reaches both the acceptance and the discard branches many times. The sweep also rotates the source that opens each fill, so that every queue is seen winning first and every wrap-around of the round-robin search is exercised. Junk fragments addressed elsewhere or sourced from port 1 are mixed into every fill, and drains alternate between an always-ready sink and a stalling one.

// File: rtl/oqb_pkg.sv
package oqb_pkg;
    typedef enum logic {
        ARB_OPEN = 1'b0,
        ARB_HELD = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/oqb_src_fifo.sv
module oqb_src_fifo #(
    parameter int DATA_W    = 64,
    parameter int DEPTH     = 256,
    parameter int MAX_FRAGS = 190
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_last,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] head_data,
    output logic              head_last,
    output logic              empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             in_pkt;
        logic             dropping;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DATA_W:0] mem_q [DEPTH];
    logic [CNT_W-1:0] free_slots;
    logic starting, fits, push, pop;

    always_comb begin
        st_d       = st_q;
        free_slots = CNT_W'(DEPTH) - st_q.count;
        fits       = free_slots >= CNT_W'(MAX_FRAGS);
        starting   = wr_valid && !st_q.in_pkt;
        push       = wr_valid && (starting ? fits : !st_q.dropping);
        pop        = rd_pop && (st_q.count != '0);
        if (push) st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        if (pop)  st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        st_d.count = st_q.count + CNT_W'(push) - CNT_W'(pop);
        if (wr_valid) begin
            st_d.in_pkt   = !wr_last;
            st_d.dropping = wr_last ? 1'b0 : (starting ? !fits : st_q.dropping);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr_ptr] <= {wr_last, wr_data};
    end

    assign head_data = mem_q[st_q.rd_ptr][DATA_W-1:0];
    assign head_last = mem_q[st_q.rd_ptr][DATA_W];
    assign empty     = (st_q.count == '0);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !(st_q.in_pkt && st_q.dropping) && (st_q.in_pkt || fits) |-> st_q.count < CNT_W'(DEPTH));

    // R8
    drop_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !st_q.in_pkt && !fits) |=> st_q.count <= $past(st_q.count));

    // R8
    drop_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && st_q.in_pkt && st_q.dropping) |=> st_q.count <= $past(st_q.count));
endmodule

// File: rtl/oqb_rr_arbiter.sv
module oqb_rr_arbiter #(
    parameter int N_REQ = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [N_REQ-1:0]                    req,
    input  logic                                beat_fire,
    input  logic                                beat_last,
    output logic [(N_REQ>1?$clog2(N_REQ):1)-1:0] grant_idx,
    output logic                                grant_valid
);
    import oqb_pkg::*;
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    typedef struct packed {
        arb_mode_e        mode;
        logic [IDX_W-1:0] sel;
        logic [IDX_W-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic [IDX_W-1:0] cand;
    logic found;

    always_comb begin
        cand  = '0;
        found = 1'b0;
        for (int k = 1; k <= N_REQ; k++) begin
            if (!found && req[(int'(st_q.ptr) + k) % N_REQ]) begin
                found = 1'b1;
                cand  = IDX_W'((int'(st_q.ptr) + k) % N_REQ);
            end
        end
        grant_idx   = (st_q.mode == ARB_HELD) ? st_q.sel : cand;
        grant_valid = (st_q.mode == ARB_HELD) ? req[st_q.sel] : found;

        st_d = st_q;
        if (grant_valid) begin
            if (beat_fire && beat_last) begin
                st_d.mode = ARB_OPEN;
                st_d.ptr  = grant_idx;
            end else begin
                st_d.mode = ARB_HELD;
                st_d.sel  = grant_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= ARB_OPEN;
            st_q.sel  <= '0;
            st_q.ptr  <= IDX_W'(N_REQ - 1);
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !(beat_fire && beat_last)) |=> grant_idx == $past(grant_idx));

    // R7
    fire_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_fire |-> req[grant_idx]);
endmodule

// File: rtl/reassembly_queue_bank.sv
module reassembly_queue_bank #(
    parameter int N_PORTS       = 5,
    parameter int PORT_ID       = 0,
    parameter int DATA_W        = 64,
    parameter int DEPTH         = 256,
    parameter int MAX_PKT_BYTES = 1518
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [$clog2(N_PORTS)-1:0] in_src,
    input  logic [$clog2(N_PORTS)-1:0] in_dst,
    input  logic [DATA_W-1:0]          in_data,
    input  logic                       in_last,
    output logic                       m_tvalid,
    input  logic                       m_tready,
    output logic [DATA_W-1:0]          m_tdata,
    output logic                       m_tlast,
    output logic [$clog2(N_PORTS)-1:0] m_tuser
);
    localparam int PORT_W    = $clog2(N_PORTS);
    localparam int N_SRC     = N_PORTS - 1;
    localparam int IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int FRAG_B    = DATA_W / 8;
    localparam int MAX_FRAGS = (MAX_PKT_BYTES + FRAG_B - 1) / FRAG_B;

    logic [N_SRC-1:0]  q_wr, q_pop, q_empty, q_last;
    logic [DATA_W-1:0] q_data [N_SRC];
    logic [IDX_W-1:0]  grant;
    logic              fire;
    logic              for_me;

    assign for_me = in_valid && (in_dst == PORT_W'(PORT_ID));
    assign fire   = m_tvalid && m_tready;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam int SRC_PORT = (g < PORT_ID) ? g : g + 1;
        assign q_wr[g]  = for_me && (in_src == PORT_W'(SRC_PORT));
        assign q_pop[g] = fire && (grant == IDX_W'(g));
        oqb_src_fifo #(
            .DATA_W   (DATA_W),
            .DEPTH    (DEPTH),
            .MAX_FRAGS(MAX_FRAGS)
        ) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_valid (q_wr[g]),
            .wr_last  (in_last),
            .wr_data  (in_data),
            .rd_pop   (q_pop[g]),
            .head_data(q_data[g]),
            .head_last(q_last[g]),
            .empty    (q_empty[g])
        );
    end

    oqb_rr_arbiter #(.N_REQ(N_SRC)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (~q_empty),
        .beat_fire  (fire),
        .beat_last  (m_tlast),
        .grant_idx  (grant),
        .grant_valid(m_tvalid)
    );

    assign m_tdata = q_data[grant];
    assign m_tlast = q_last[grant];
    assign m_tuser = (int'(grant) < PORT_ID) ? PORT_W'(grant) : PORT_W'(int'(grant) + 1);

    // R9
    axis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser));

    // R2
    no_self_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> m_tuser != PORT_W'(PORT_ID));

    // R3
    foreign_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !for_me) |-> q_wr == '0);
endmodule

// File: tb/reassembly_queue_bank_test.sv
module reassembly_queue_bank_test;
    localparam int NP = 4, PID = 1, DW = 16, DEP = 8, MAXB = 8;
    localparam int NS = NP - 1, MF = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, m_tready = 1'b0;
    logic [1:0] in_src = '0, in_dst = '0;
    logic [DW-1:0] in_data = '0;
    logic m_tvalid, m_tlast;
    logic [DW-1:0] m_tdata;
    logic [1:0] m_tuser;

    reassembly_queue_bank #(.N_PORTS(NP), .PORT_ID(PID), .DATA_W(DW), .DEPTH(DEP),
        .MAX_PKT_BYTES(MAXB)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src), .in_dst(in_dst),
        .in_data(in_data), .in_last(in_last), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tuser(m_tuser));

    always #2.5 clk = ~clk;

    int vectors = 0, miscompares = 0, cyc = 0;
    bit done = 1'b0;

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            miscompares++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    function automatic int port_of(int q);
        return (q < PID) ? q : q + 1;
    endfunction

    task automatic send(logic [1:0] s, logic [1:0] d, logic [DW-1:0] dat, logic lst);
        @(negedge clk);
        in_valid = 1'b1; in_src = s; in_dst = d; in_data = dat; in_last = lst;
        @(posedge clk);
    endtask

    logic [DW-1:0] ed [NS][6][4];
    int elen [NS][6];
    int ecnt [NS];
    int npk [NS];
    int plen [NS][6];

    initial begin
        for (int t = 0; t < 40; t++) begin
            int occ [NS];
            int pk [NS];
            int wd [NS];
            int rot, firstq, steps;
            bit got_first, drop_cur [NS];
            logic [DW-1:0] sq_d [64];
            logic sq_l [64];
            int sq_u [64];
            int total, cur, ptr, taken [NS], nb, stall_v;
            logic [DW-1:0] held;

            // reset
            @(negedge clk);
            rst_n = 1'b0; in_valid = 1'b0; m_tready = 1'b0;
            @(negedge clk); @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            chk(m_tvalid == 1'b0, "R1 reset valid", int'(m_tvalid), 0);

            for (int q = 0; q < NS; q++) begin
                npk[q] = (t + q) % 5;
                occ[q] = 0; pk[q] = 0; wd[q] = 0; ecnt[q] = 0; taken[q] = 0;
                drop_cur[q] = 1'b0;
                for (int p = 0; p < 6; p++) plen[q][p] = ((t * 3 + q * 5 + p * 7) % 4) + 1;
            end

            // junk first: foreign destination, own-port source
            send(2'd0, 2'd2, 16'hdead, 1'b1);
            send(2'(PID), 2'(PID), 16'hbeef, 1'b0);
            @(negedge clk); in_valid = 1'b0;
            @(negedge clk);
            chk(m_tvalid == 1'b0, "R3 junk ignored", int'(m_tvalid), 0);

            rot = t % NS; got_first = 1'b0; firstq = 0; steps = 0;
            forever begin
                int pick;
                pick = -1;
                for (int k = 0; k < NS; k++) begin
                    int qq;
                    qq = (rot + k) % NS;
                    if (pick < 0 && pk[qq] < npk[qq]) pick = qq;
                end
                if (pick < 0) break;
                steps++;
                if (steps % 4 == 3) send(2'(PID), 2'(PID), 16'h1111, 1'b1);
                if (steps % 5 == 4) send(2'd3, 2'd0, 16'h2222, 1'b0);
                begin
                    logic [DW-1:0] w;
                    bit lst;
                    w = {4'(pick), 4'(pk[pick]), 4'(wd[pick]), 4'(t)};
                    lst = (wd[pick] == plen[pick][pk[pick]] - 1);
                    if (wd[pick] == 0) begin
                        drop_cur[pick] = !((DEP - occ[pick]) >= MF);
                        if (!drop_cur[pick]) begin
                            occ[pick] += plen[pick][pk[pick]];
                            elen[pick][ecnt[pick]] = plen[pick][pk[pick]];
                            ecnt[pick]++;
                        end
                    end
                    if (!drop_cur[pick]) ed[pick][ecnt[pick] - 1][wd[pick]] = w;
                    send(2'(port_of(pick)), 2'(PID), w, lst);
                    if (!got_first) begin
                        got_first = 1'b1; firstq = pick;
                        @(negedge clk); in_valid = 1'b0;
                        chk(m_tvalid == 1'b1, "R7 valid after first write", int'(m_tvalid), 1);
                    end
                    if (lst) begin wd[pick] = 0; pk[pick]++; end
                    else wd[pick]++;
                end
                rot = (pick + 1) % NS;
            end
            @(negedge clk); in_valid = 1'b0;

            // expected output sequence
            total = 0;
            for (int q = 0; q < NS; q++) total += ecnt[q];
            nb = 0; cur = firstq;
            for (int n = 0; n < total; n++) begin
                for (int w = 0; w < elen[cur][taken[cur]]; w++) begin
                    sq_d[nb] = ed[cur][taken[cur]][w];
                    sq_l[nb] = (w == elen[cur][taken[cur]] - 1);
                    sq_u[nb] = port_of(cur);
                    nb++;
                end
                taken[cur]++;
                ptr = cur;
                for (int k = 1; k <= NS; k++) begin
                    int qq;
                    qq = (ptr + k) % NS;
                    if (qq != ptr || k == NS)
                        if (taken[qq] < ecnt[qq] && cur == ptr) cur = qq;
                end
            end

            // drain
            begin
                int got, dc;
                bit was_stall;
                got = 0; dc = 0; was_stall = 1'b0; held = '0; stall_v = 0;
                while (got < nb && dc < 400) begin
                    bit rdy;
                    @(negedge clk);
                    rdy = (t % 2 == 0) ? 1'b1 : (dc % 3 != 2);
                    m_tready = rdy;
                    #1;
                    if (was_stall) begin
                        chk(m_tvalid == 1'b1 && m_tdata == held, "R9 hold under stall",
                            int'(m_tdata), int'(held));
                    end
                    was_stall = m_tvalid && !rdy;
                    held = m_tdata;
                    if (m_tvalid && rdy) begin
                        chk(m_tdata == sq_d[got], "R4 beat data", int'(m_tdata), int'(sq_d[got]));
                        chk(m_tlast == sq_l[got], "R5 beat last", int'(m_tlast), int'(sq_l[got]));
                        chk(int'(m_tuser) == sq_u[got], "R6 R2 source order", int'(m_tuser), sq_u[got]);
                        got++;
                    end
                    dc++;
                end
                chk(got == nb, "R8 accepted beat count", got, nb);
                @(negedge clk);
                m_tready = 1'b1;
                #1;
                chk(m_tvalid == 1'b0, "R8 no extra beats", int'(m_tvalid), 0);
                @(negedge clk);
                m_tready = 1'b0;
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule